// File: doc/BRIEF.md
# I2C Status Flag and Interrupt Controller

This block keeps the flags of a multi-master I2C peripheral that hardware updates, and it raises the peripheral's interrupt. There are three flags. The first is an active-low pending-interrupt flag, `pin`. The second is a bus-in-use flag, `bb`. The third is a transfer-direction flag, `trx`. While `pin` is low the block asks the clock generator to hold SCL low. The byte engine and the bus condition detectors feed the block with single-cycle event pulses. Mode bits select master or slave operation, address-reception handling, wait-before-acknowledge, and whether the peripheral is enabled at all.

Software releases a pending byte by writing the data shift register. It can also write the clock control register, but that releases only an interrupt raised by the wait-before-acknowledge feature. Software can load the direction flag through the control-word write strobe. The pending flag is read-only, so its bit in that write is ignored.

Every flag updates on the clock edge that follows the cycle in which its event pulse is high.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: While `rst_n` is low, at the next edge `pin`=1, `bb`=0, `trx`=0, `irq`=0 and `scl_hold`=0.
- R2: With `en`=1, a pulse on `ev_byte_done` or `ev_arb_lost` makes `pin`=0 and `scl_hold`=1 from the next cycle. This holds whatever `pin` was before.
- R3: `irq` is high for exactly the one cycle in which `pin` first reads 0 after reading 1. A new falling event while `pin` is already 0 gives no `irq`.
- R4: With `en`=1, `wit`=1 and `ack_clk_en`=1, a pulse on `ev_data_done` makes `pin`=0 and sets an internal wait flag. If `wit` or `ack_clk_en` is 0, `ev_data_done` has no effect on `pin`.
- R5: `sw_wr_data` sets `pin`=1 at the next edge. `sw_wr_clk` sets `pin`=1 only when `wit`=1 and the wait flag is set, and it then clears the wait flag. The wait flag is also cleared by `sw_wr_data` and by `ev_byte_done`. When a falling event and a release come in the same cycle, the falling event wins.
- R6: With `mst`=0 and `ev_addr_done` pulsing, `pin` falls in two cases. With `als`=1 it falls after any address byte. With `als`=0 it falls only if `addr_match` or `gen_call` is 1. With `mst`=1, `ev_addr_done` has no effect on `pin`.
- R7: `ev_start` sets `bb`=1 and `ev_stop` clears it, in either master or slave mode. If both come in the same cycle, `bb`=0.
- R8: With `mst`=0, `als`=0, `addr_match`=1 and `rx_rw`=1, a pulse on `ev_addr_done` sets `trx`=1.
- R9: Any of these clears `trx` to 0, and a clear wins over a set in the same cycle: `ev_arb_lost`, `ev_stop`, `ev_start_sup`, `ev_start` with `mst`=0, or `ev_nack` with `mst`=0.
- R10: `sw_wr_ctrl` loads `sw_trx_val` into `trx`. A hardware set or clear of `trx` in the same cycle takes priority over the load.
- R11: While `en`=0, from the next edge `pin`=1, `bb`=0, `trx`=0 and `irq`=0, and the wait flag is cleared. All events and writes are ignored.
- R12: A `sw_wr_ctrl` write never changes `pin`, whatever the value of `sw_pin_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Peripheral enable |
| mst | input | 1 | 1 = master mode |
| als | input | 1 | 1 = every address byte raises the interrupt |
| wit | input | 1 | Wait-before-acknowledge enable |
| ack_clk_en | input | 1 | ACK clock mode enabled |
| ev_data_done | input | 1 | Pulse: last data bit clock ended (before ACK) |
| ev_byte_done | input | 1 | Pulse: byte finished, including ACK clock |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_addr_done | input | 1 | Pulse: slave address byte received |
| addr_match | input | 1 | Own address matched (valid with ev_addr_done) |
| gen_call | input | 1 | General call seen (valid with ev_addr_done) |
| rx_rw | input | 1 | Received R/W bit (valid with ev_addr_done) |
| ev_start | input | 1 | Pulse: START detected |
| ev_stop | input | 1 | Pulse: STOP detected |
| ev_start_sup | input | 1 | Pulse: START suppressed as a duplicate |
| ev_nack | input | 1 | Pulse: no ACK returned |
| sw_wr_data | input | 1 | Software write to data shift register |
| sw_wr_clk | input | 1 | Software write to clock control register |
| sw_wr_ctrl | input | 1 | Software write to the flag control word |
| sw_trx_val | input | 1 | Direction bit of that write |
| sw_pin_val | input | 1 | Pending bit of that write (ignored) |
| pin | output | 1 | Pending-interrupt flag, active low |
| bb | output | 1 | Bus busy |
| trx | output | 1 | 1 = transmit direction |
| irq | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Hold SCL low |

## Verification
Every flag is due one clock edge after the cycle in which its pulse or write was driven. `irq` is due in the same cycle as the first low `pin`, and `scl_hold` in the same cycle as the `pin` value it mirrors. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge, using the inputs held across that edge. It compares all five outputs to the model on the next falling edge, which is exactly where each one-edge result has settled. Directed sequences cover the priority collisions and mode gates. A long random mix then runs under the same per-cycle comparison.

// File: rtl/i2c_flag_pkg.sv
// Package: reset and idle values shared by the flag units.
// Assumes: the pending flag is active low, so its idle value is 1.
package i2c_flag_pkg;
    localparam logic PIN_IDLE = 1'b1;
    localparam logic BB_IDLE  = 1'b0;
    localparam logic TRX_IDLE = 1'b0;
endpackage

// File: rtl/i2c_pin_unit.sv
// Pending-interrupt flag, internal wait flag, interrupt pulse and SCL hold.
// Assumes: every event input is a synchronous single-cycle pulse; en=0 acts as a reset.
module i2c_pin_unit
    import i2c_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mst,
    input  logic als,
    input  logic wit,
    input  logic ack_clk_en,
    input  logic ev_data_done,
    input  logic ev_byte_done,
    input  logic ev_arb_lost,
    input  logic ev_addr_done,
    input  logic addr_match,
    input  logic gen_call,
    input  logic sw_wr_data,
    input  logic sw_wr_clk,
    input  logic sw_wr_ctrl,
    input  logic sw_pin_val,
    output logic pin,
    output logic irq,
    output logic scl_hold
);
    logic pin_q, irq_q, wait_q;
    logic wait_fall, addr_fall, fall, release_req, pin_n;

    // Decode the falling events and the software release.
    always_comb begin
        wait_fall   = wit && ack_clk_en && ev_data_done;
        addr_fall   = ev_addr_done && !mst && (als || addr_match || gen_call);
        fall        = ev_byte_done || ev_arb_lost || wait_fall || addr_fall;
        release_req = sw_wr_data || (sw_wr_clk && wit && wait_q);
        pin_n       = fall ? 1'b0 : (release_req ? 1'b1 : pin_q);
    end

    // Register the pending flag and the interrupt pulse on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pin_q <= PIN_IDLE;
            irq_q <= 1'b0;
        end else begin
            pin_q <= pin_n;
            irq_q <= pin_q && !pin_n;
        end
    end

    // Track the wait flag set by a wait-mode fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            wait_q <= 1'b0;
        else if (wait_fall)
            wait_q <= 1'b1;
        else if (release_req || ev_byte_done)
            wait_q <= 1'b0;
    end

    assign pin      = pin_q;
    assign irq      = irq_q;
    assign scl_hold = !pin_q;

    p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (ev_byte_done || ev_arb_lost)) |=> (!pin && scl_hold));
    p_irq_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!pin && $past(pin)));
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sw_wr_data && !fall) |=> pin);
    p_ro_pin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pin && sw_wr_ctrl && !sw_pin_val && !fall) |=> pin);
    p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pin && !irq));
endmodule

// File: rtl/i2c_bb_unit.sv
// Bus busy flag: set by START, cleared by STOP, in either master or slave mode.
// Assumes: START and STOP are single-cycle pulses; a STOP wins a same-cycle collision.
module i2c_bb_unit
    import i2c_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ev_start,
    input  logic ev_stop,
    output logic bb
);
    logic bb_q;

    // Update the bus busy flag from the detected bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            bb_q <= BB_IDLE;
        else if (ev_stop)
            bb_q <= 1'b0;
        else if (ev_start)
            bb_q <= 1'b1;
    end

    assign bb = bb_q;

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev_start && !ev_stop) |=> bb);
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ev_stop) |=> !bb);
    p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bb);
endmodule

// File: rtl/i2c_trx_unit.sv
// Transfer direction flag with hardware set and clear paths and a software load.
// Assumes: a hardware clear beats a hardware set, and both beat a software load.
module i2c_trx_unit
    import i2c_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mst,
    input  logic als,
    input  logic ev_arb_lost,
    input  logic ev_stop,
    input  logic ev_start_sup,
    input  logic ev_start,
    input  logic ev_nack,
    input  logic ev_addr_done,
    input  logic addr_match,
    input  logic rx_rw,
    input  logic sw_wr_ctrl,
    input  logic sw_trx_val,
    output logic trx
);
    logic trx_q, hw_clr, hw_set;

    // Decode the hardware clear and set conditions.
    always_comb begin
        hw_clr = ev_arb_lost || ev_stop || ev_start_sup ||
                 (!mst && (ev_start || ev_nack));
        hw_set = ev_addr_done && !mst && !als && addr_match && rx_rw;
    end

    // Update the direction flag in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            trx_q <= TRX_IDLE;
        else if (hw_clr)
            trx_q <= 1'b0;
        else if (hw_set)
            trx_q <= 1'b1;
        else if (sw_wr_ctrl)
            trx_q <= sw_trx_val;
    end

    assign trx = trx_q;

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mst && !als && ev_addr_done && addr_match && rx_rw && !hw_clr) |=> trx);
    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (ev_arb_lost || ev_stop || ev_start_sup)) |=> !trx);
    p_hw_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sw_wr_ctrl && sw_trx_val && ev_stop) |=> !trx);
    p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !trx);
endmodule

// File: rtl/i2c_flag_ctrl.sv
// Top: status flags and interrupt of a multi-master I2C peripheral.
// Assumes: event inputs are synchronous single-cycle pulses; the byte engine,
// the START/STOP detector and clock generation sit outside this block.
module i2c_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mst,
    input  logic als,
    input  logic wit,
    input  logic ack_clk_en,
    input  logic ev_data_done,
    input  logic ev_byte_done,
    input  logic ev_arb_lost,
    input  logic ev_addr_done,
    input  logic addr_match,
    input  logic gen_call,
    input  logic rx_rw,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_start_sup,
    input  logic ev_nack,
    input  logic sw_wr_data,
    input  logic sw_wr_clk,
    input  logic sw_wr_ctrl,
    input  logic sw_trx_val,
    input  logic sw_pin_val,
    output logic pin,
    output logic bb,
    output logic trx,
    output logic irq,
    output logic scl_hold
);
    i2c_pin_unit u_pin (
        .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .als(als), .wit(wit),
        .ack_clk_en(ack_clk_en), .ev_data_done(ev_data_done),
        .ev_byte_done(ev_byte_done), .ev_arb_lost(ev_arb_lost),
        .ev_addr_done(ev_addr_done), .addr_match(addr_match), .gen_call(gen_call),
        .sw_wr_data(sw_wr_data), .sw_wr_clk(sw_wr_clk), .sw_wr_ctrl(sw_wr_ctrl),
        .sw_pin_val(sw_pin_val), .pin(pin), .irq(irq), .scl_hold(scl_hold)
    );

    i2c_bb_unit u_bb (
        .clk(clk), .rst_n(rst_n), .en(en), .ev_start(ev_start), .ev_stop(ev_stop),
        .bb(bb)
    );

    i2c_trx_unit u_trx (
        .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .als(als),
        .ev_arb_lost(ev_arb_lost), .ev_stop(ev_stop), .ev_start_sup(ev_start_sup),
        .ev_start(ev_start), .ev_nack(ev_nack), .ev_addr_done(ev_addr_done),
        .addr_match(addr_match), .rx_rw(rx_rw), .sw_wr_ctrl(sw_wr_ctrl),
        .sw_trx_val(sw_trx_val), .trx(trx)
    );

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin) |-> (scl_hold && irq));
endmodule

// File: tb/tb_i2c_flag_ctrl.sv
// Bench: behavioural model stepped on the rising edge, compared on the falling edge.
module tb_i2c_flag_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, mst = 0, als = 0, wit = 0, ack_clk_en = 0;
    logic ev_data_done = 0, ev_byte_done = 0, ev_arb_lost = 0, ev_addr_done = 0;
    logic addr_match = 0, gen_call = 0, rx_rw = 0;
    logic ev_start = 0, ev_stop = 0, ev_start_sup = 0, ev_nack = 0;
    logic sw_wr_data = 0, sw_wr_clk = 0, sw_wr_ctrl = 0, sw_trx_val = 0, sw_pin_val = 0;
    logic pin, bb, trx, irq, scl_hold;

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    string phase = "R1 reset";
    int m_pin = 1, m_bb = 0, m_trx = 0, m_irq = 0, m_wait = 0;

    always #2 clk = ~clk;

    i2c_flag_ctrl dut (.*);

    // Reference model: next state from the inputs held across this edge.
    always @(posedge clk) begin
        int fall, wfall, rel, npin;
        if (!rst_n || !en) begin
            m_pin = 1; m_bb = 0; m_trx = 0; m_irq = 0; m_wait = 0;
        end else begin
            wfall = int'(wit && ack_clk_en && ev_data_done);
            fall  = int'(ev_byte_done || ev_arb_lost || wfall ||
                         (ev_addr_done && !mst && (als || addr_match || gen_call)));
            rel   = int'(sw_wr_data || (sw_wr_clk && wit && m_wait != 0));
            npin  = fall != 0 ? 0 : (rel != 0 ? 1 : m_pin);
            m_irq = (m_pin == 1 && npin == 0) ? 1 : 0;
            m_pin = npin;
            if (wfall != 0) m_wait = 1;
            else if (rel != 0 || ev_byte_done) m_wait = 0;
            if (ev_stop) m_bb = 0;
            else if (ev_start) m_bb = 1;
            if (ev_arb_lost || ev_stop || ev_start_sup || (!mst && (ev_start || ev_nack)))
                m_trx = 0;
            else if (ev_addr_done && !mst && !als && addr_match && rx_rw)
                m_trx = 1;
            else if (sw_wr_ctrl)
                m_trx = int'(sw_trx_val);
        end
    end

    task automatic cmp(string name, logic act, int exp);
        vectors++;
        if (act !== 1'(exp)) begin
            miscompares++;
            $display("FAIL [%s] %s actual=%b expected=%0d", phase, name, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            cmp("pin", pin, m_pin);
            cmp("bb", bb, m_bb);
            cmp("trx", trx, m_trx);
            cmp("irq", irq, m_irq);
            cmp("scl_hold", scl_hold, 1 - m_pin);
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_data_done = 0; ev_byte_done = 0; ev_arb_lost = 0; ev_addr_done = 0;
            ev_start = 0; ev_stop = 0; ev_start_sup = 0; ev_nack = 0;
            sw_wr_data = 0; sw_wr_clk = 0; sw_wr_ctrl = 0;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL [watchdog, all requirements] actual=hung expected=done");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1; en = 1; ack_clk_en = 1;
        step(2);
        phase = "R2 byte done";      ev_byte_done = 1; step(); step();
        phase = "R3 no repeat irq";  ev_byte_done = 1; step(); step();
        phase = "R5 data release";   sw_wr_data = 1; step(); step();
        phase = "R2 arb lost";       ev_arb_lost = 1; step(); sw_wr_data = 1; step(); step();
        phase = "R4 wit off";        wit = 0; ev_data_done = 1; step(); step();
        phase = "R4 ack clk off";    wit = 1; ack_clk_en = 0; ev_data_done = 1; step(); step();
        phase = "R4 wait fall";      ack_clk_en = 1; ev_data_done = 1; step(); step();
        phase = "R5 clk release";    sw_wr_clk = 1; step(); step();
        phase = "R5 clk no wait";    ev_byte_done = 1; step(); sw_wr_clk = 1; step(); step();
        phase = "R5 fall beats rel"; sw_wr_data = 1; step(); ev_byte_done = 1; sw_wr_data = 1; step(); step();
        sw_wr_data = 1; step(); wit = 0;
        phase = "R6 als0 nomatch";   ev_addr_done = 1; step(); step();
        phase = "R6 gen call";       ev_addr_done = 1; gen_call = 1; step(); gen_call = 0; sw_wr_data = 1; step();
        phase = "R6 als1 any";       als = 1; ev_addr_done = 1; step(); sw_wr_data = 1; step();
        phase = "R6 master";         mst = 1; ev_addr_done = 1; step(); step(); mst = 0; als = 0;
        phase = "R7 start";          ev_start = 1; step(); step();
        phase = "R7 stop";           ev_stop = 1; step(); step();
        phase = "R7 both";           ev_start = 1; step(); ev_start = 1; ev_stop = 1; step(); step();
        phase = "R8 slave tx";       ev_addr_done = 1; addr_match = 1; rx_rw = 1; step(); sw_wr_data = 1; step();
        phase = "R9 nack slave";     ev_nack = 1; step(); step();
        phase = "R9 clr over set";   ev_addr_done = 1; ev_start_sup = 1; step(); sw_wr_data = 1; step();
        phase = "R10 sw load";       sw_wr_ctrl = 1; sw_trx_val = 1; step(); step();
        phase = "R9 master start";   mst = 1; ev_start = 1; ev_nack = 1; step(); step();
        phase = "R10 hw first";      sw_wr_ctrl = 1; ev_arb_lost = 1; step(); sw_wr_data = 1; step(); mst = 0;
        phase = "R12 pin read only"; sw_wr_ctrl = 1; sw_pin_val = 0; sw_trx_val = 1; step(); step();
        ev_byte_done = 1; step(); sw_wr_ctrl = 1; sw_pin_val = 1; step(); step();
        phase = "R11 disabled";      ev_start = 1; step(); en = 0; ev_byte_done = 1; ev_start = 1; step();
        ev_addr_done = 1; rx_rw = 1; step(); step(2); en = 1; step();
        phase = "R1 reset again";    ev_start = 1; ev_byte_done = 1; step(); rst_n = 0; step(2); rst_n = 1;
        phase = "random R2 R5 R7 R9 R10";
        for (int k = 0; k < 4000; k++) begin
            en = ($urandom_range(0, 49) != 0);
            mst = 1'($urandom); als = 1'($urandom); wit = 1'($urandom);
            ack_clk_en = 1'($urandom); addr_match = 1'($urandom);
            gen_call = 1'($urandom); rx_rw = 1'($urandom);
            ev_data_done = ($urandom_range(0, 7) == 0);
            ev_byte_done = ($urandom_range(0, 9) == 0);
            ev_arb_lost  = ($urandom_range(0, 19) == 0);
            ev_addr_done = ($urandom_range(0, 7) == 0);
            ev_start     = ($urandom_range(0, 7) == 0);
            ev_stop      = ($urandom_range(0, 9) == 0);
            ev_start_sup = ($urandom_range(0, 19) == 0);
            ev_nack      = ($urandom_range(0, 11) == 0);
            sw_wr_data   = ($urandom_range(0, 5) == 0);
            sw_wr_clk    = ($urandom_range(0, 5) == 0);
            sw_wr_ctrl   = ($urandom_range(0, 5) == 0);
            sw_trx_val = 1'($urandom); sw_pin_val = 1'($urandom);
            step();
        end
        step(2);
        finish_run();
    end
endmodule